// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits beside a processor's execution pipeline. At each instruction boundary it collects every exception that is waiting: the two interrupt lines, the two abort flags, the undefined-instruction flag and the software-interrupt flag. It picks one winner by a fixed ranking. Reset release is treated separately, as the top-ranked request, and is taken in the first cycle after the core reset input drops, with no boundary needed.

For the winning exception the block computes the following:
- the handler address,
- the new 32-bit status word, with the mode field rewritten and the interrupt masks set,
- an unchanged copy of the old status word,
- the return link.

It presents these one clock later together with a single-cycle entry strobe. The surrounding core loads its program counter, banked link register and saved-status register from these outputs. Between entries all outputs keep their last values.

Both interrupt inputs are active low and may change at any time. Each first passes through one synchronising flop. An interrupt is honoured only when that flop's output is low at an instruction end and the matching mask bit in the current status is clear.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Ranking, highest first: reset release, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction / software interrupt. Exactly one exception is entered per strobe.
- R2: Handler addresses are as follows:
  - reset 0x00
  - undefined 0x04
  - software interrupt 0x08
  - prefetch abort 0x0C
  - data abort 0x10
  - normal interrupt 0x18
  - fast interrupt 0x1C
  
  0x14 is never produced.
- R3: The new status bits [4:0] hold the entry mode:
  - fast interrupt 10001
  - normal interrupt 10010
  - reset and software interrupt 10011
  - both aborts 10111
  - undefined 11011
- R4: Every entry sets status bit 7 (normal-interrupt mask). Bit 6 (fast-interrupt mask) is set only on fast-interrupt and reset entry and is otherwise copied. Bits [31:8] and bit 5 are copied from the current status.
- R5: On entry, the saved-status output equals the status input sampled at the deciding clock edge.
- R6: On entry the link output equals the sampled instruction address plus 8 for a data abort. For every other non-reset exception it is that address plus 4.
- R7: Interrupt lines pass through one synchronising flop. An interrupt is taken only at an instruction end where the synchronised level is low and its mask (bit 6 fast, bit 7 normal) is clear. A newly lowered line therefore enters one clock later than a flag raised at the same time.
- R8: Except for reset release, requests are evaluated only on a clock edge where `insn_end_i` is high.
- R9: While `core_rst_i` is high no entry occurs. In the first cycle after it falls, entry goes to 0x00 in mode 10011 with bits 7 and 6 set, regardless of `insn_end_i`.
- R10: When no exception is chosen, `enter_o` stays low and the vector, status, saved-status and link outputs hold their values.
- R11: The synchronous active-low `rst_n` clears `enter_o` and all data outputs to zero and presets both synchronising flops to the inactive high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| fiq_n_i | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_n_i | input | 1 | Normal interrupt request, active low, asynchronous |
| dabt_i | input | 1 | Data abort pending |
| pabt_i | input | 1 | Prefetch abort pending |
| und_i | input | 1 | Undefined instruction pending |
| swi_i | input | 1 | Software interrupt pending |
| core_rst_i | input | 1 | Core reset, active high |
| insn_end_i | input | 1 | Instruction boundary in this cycle |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Instruction address used for the link |
| enter_o | output | 1 | One-cycle entry strobe |
| vector_o | output | 32 | Handler address |
| status_new_o | output | 32 | Status word after entry |
| status_saved_o | output | 32 | Copy of the old status word |
| link_o | output | 32 | Return link value |

## Verification
The central collision is a data abort and a fast interrupt resolving on the same boundary. The fast line is lowered one clock before the abort flag, so that both are live at the same edge. The first entry must then carry vector 0x10, link +8 and F copied. Once the abort flag is withdrawn, the next boundary must yield the fast-interrupt entry with F set.

Other same-edge pairings are covered as well:
- reset release against a held data abort;
- a normal interrupt against a prefetch abort;
- a prefetch abort against an undefined instruction.

In each case the bench checks the vector and mode of both entries in order.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int EXC_NUM = 7;

  // Index order equals priority order (0 = highest).
  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_DABT = 3'd1,
    EXC_FIQ  = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_PABT = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SWI  = 3'd6,
    EXC_NONE = 3'd7
  } exc_kind_e;

  function automatic logic [7:0] exc_vector(input exc_kind_e k);
    case (k)
      EXC_RST:  return 8'h00;
      EXC_UND:  return 8'h04;
      EXC_SWI:  return 8'h08;
      EXC_PABT: return 8'h0C;
      EXC_DABT: return 8'h10;
      EXC_IRQ:  return 8'h18;
      EXC_FIQ:  return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] exc_mode(input exc_kind_e k);
    case (k)
      EXC_FIQ:            return 5'b10001;
      EXC_IRQ:            return 5'b10010;
      EXC_RST, EXC_SWI:   return 5'b10011;
      EXC_DABT, EXC_PABT: return 5'b10111;
      EXC_UND:            return 5'b11011;
      default:            return 5'b10011;
    endcase
  endfunction

  function automatic logic [3:0] exc_link_ofs(input exc_kind_e k);
    return (k == EXC_DABT) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic exc_sets_f(input exc_kind_e k);
    return (k == EXC_FIQ) || (k == EXC_RST);
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // One capture stage per line; reset level is the inactive high.
  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '1;
    else        dout <= din;
  end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rank
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
    end
  endgenerate

  assign any = blocked[N];
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int MODE_W = 5,
  parameter int I_BIT  = 7,
  parameter int F_BIT  = 6
) (
  input  exc_kind_e          kind,
  input  logic [STAT_W-1:0]  status,
  input  logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  vector,
  output logic [STAT_W-1:0]  status_new,
  output logic [ADDR_W-1:0]  link
);
  localparam int VEC_W = 8;

  always_comb begin
    vector = {{(ADDR_W-VEC_W){1'b0}}, exc_vector(kind)};
    link   = pc + ADDR_W'(exc_link_ofs(kind));
    status_new = status;
    status_new[MODE_W-1:0] = exc_mode(kind);
    status_new[I_BIT] = 1'b1;
    if (exc_sets_f(kind)) status_new[F_BIT] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int MODE_W = 5,
  parameter int I_BIT  = 7,
  parameter int F_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_n_i,
  input  logic              irq_n_i,
  input  logic              dabt_i,
  input  logic              pabt_i,
  input  logic              und_i,
  input  logic              swi_i,
  input  logic              core_rst_i,
  input  logic              insn_end_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              enter_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [STAT_W-1:0] status_new_o,
  output logic [STAT_W-1:0] status_saved_o,
  output logic [ADDR_W-1:0] link_o
);
  localparam int N_SYNC = 2;

  // Synchronised interrupt levels: [1] fast, [0] normal
  logic [N_SYNC-1:0] irq_lines_s;
  exc_sync #(.WIDTH(N_SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({fiq_n_i, irq_n_i}),
    .dout (irq_lines_s)
  );
  logic fiq_s_n, irq_s_n;
  assign fiq_s_n = irq_lines_s[1];
  assign irq_s_n = irq_lines_s[0];

  // Core reset edge detection
  logic core_rst_q;
  always_ff @(posedge clk) begin
    if (!rst_n) core_rst_q <= 1'b0;
    else        core_rst_q <= core_rst_i;
  end

  logic rst_release;
  logic boundary;
  assign rst_release = core_rst_q & ~core_rst_i;
  assign boundary    = insn_end_i & ~core_rst_i;

  // Request vector, indexed by priority rank
  logic [EXC_NUM-1:0] req;
  always_comb begin
    req = '0;
    req[EXC_RST]  = rst_release;
    req[EXC_DABT] = boundary & dabt_i;
    req[EXC_FIQ]  = boundary & ~fiq_s_n & ~status_i[F_BIT];
    req[EXC_IRQ]  = boundary & ~irq_s_n & ~status_i[I_BIT];
    req[EXC_PABT] = boundary & pabt_i;
    req[EXC_UND]  = boundary & und_i;
    req[EXC_SWI]  = boundary & swi_i;
  end

  logic [EXC_NUM-1:0] grant;
  logic               take;
  exc_prio_arb #(.N(EXC_NUM)) u_arb (
    .req  (req),
    .grant(grant),
    .any  (take)
  );

  exc_kind_e win_kind;
  always_comb begin
    win_kind = EXC_NONE;
    for (int k = 0; k < EXC_NUM; k++) begin
      if (grant[k]) win_kind = exc_kind_e'(k);
    end
  end

  logic [ADDR_W-1:0] nxt_vector, nxt_link;
  logic [STAT_W-1:0] nxt_status;
  exc_entry_calc #(
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .MODE_W(MODE_W),
    .I_BIT(I_BIT), .F_BIT(F_BIT)
  ) u_calc (
    .kind      (win_kind),
    .status    (status_i),
    .pc        (pc_i),
    .vector    (nxt_vector),
    .status_new(nxt_status),
    .link      (nxt_link)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enter_o        <= 1'b0;
      vector_o       <= '0;
      status_new_o   <= '0;
      status_saved_o <= '0;
      link_o         <= '0;
    end else begin
      enter_o <= take;
      if (take) begin
        vector_o       <= nxt_vector;
        status_new_o   <= nxt_status;
        status_saved_o <= status_i;
        link_o         <= nxt_link;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int NREQ   = 7,
  parameter int I_BIT  = 7,
  parameter int F_BIT  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_i,
  input logic              insn_end_i,
  input logic [STAT_W-1:0] status_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              enter_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [STAT_W-1:0] status_new_o,
  input logic [STAT_W-1:0] status_saved_o,
  input logic [ADDR_W-1:0] link_o,
  input logic              rst_release,
  input logic [NREQ-1:0]   grant
);
  localparam logic [ADDR_W-1:0] V_DABT = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] V_FIQ  = ADDR_W'(32'h1C);
  localparam logic [ADDR_W-1:0] V_RSV  = ADDR_W'(32'h14);
  localparam logic [ADDR_W-1:0] V_RST  = ADDR_W'(32'h00);

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> (vector_o != V_RSV) && (vector_o[1:0] == 2'b00) && (vector_o < ADDR_W'(32'h20))); // R2

  AST_DABT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && vector_o == V_DABT) |-> status_new_o[4:0] == 5'b10111); // R3

  AST_I_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> status_new_o[I_BIT]); // R4

  AST_F_MASK_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && vector_o == V_FIQ) |-> status_new_o[F_BIT]); // R4

  AST_SAVED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && !$past(rst_release)) |-> status_saved_o == $past(status_i)); // R5

  AST_LINK_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && vector_o != V_RST) |->
      link_o == $past(pc_i) + ((vector_o == V_DABT) ? ADDR_W'(8) : ADDR_W'(4))); // R6

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> ($past(insn_end_i) || $past(rst_release))); // R8

  AST_NO_ENTRY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_rst_i) |-> !enter_o); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_o |-> $stable(vector_o) && $stable(link_o) && $stable(status_new_o)
                 && $stable(status_saved_o)); // R10
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .ADDR_W(ADDR_W), .STAT_W(STAT_W), .NREQ(exc_pkg::EXC_NUM),
  .I_BIT(I_BIT), .F_BIT(F_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_rst_i    (core_rst_i),
  .insn_end_i    (insn_end_i),
  .status_i      (status_i),
  .pc_i          (pc_i),
  .enter_o       (enter_o),
  .vector_o      (vector_o),
  .status_new_o  (status_new_o),
  .status_saved_o(status_saved_o),
  .link_o        (link_o),
  .rst_release   (rst_release),
  .grant         (grant)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fiq_n = 1'b1, irq_n = 1'b1;
  logic        dabt = 1'b0, pabt = 1'b0, und = 1'b0, swi = 1'b0;
  logic        core_rst = 1'b0, insn_end = 1'b0;
  logic [31:0] status = 32'h6000_0010, pc = 32'h0000_0100;
  logic        enter;
  logic [31:0] vector, st_new, st_saved, link;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .fiq_n_i(fiq_n), .irq_n_i(irq_n),
    .dabt_i(dabt), .pabt_i(pabt), .und_i(und), .swi_i(swi),
    .core_rst_i(core_rst), .insn_end_i(insn_end),
    .status_i(status), .pc_i(pc),
    .enter_o(enter), .vector_o(vector), .status_new_o(st_new),
    .status_saved_o(st_saved), .link_o(link)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Mode in [4:0], mask I at bit 7, F at bit 6 when requested
  function automatic logic [31:0] want_status(input logic [31:0] s, input logic [4:0] m,
                                              input bit f);
    logic [31:0] r;
    r = {s[31:8], 1'b1, (s[6] | f), s[5], m};
    return r;
  endfunction

  task automatic expect_entry(input string req, input logic [31:0] vec,
                              input logic [4:0] m, input bit f, input int ofs);
    chk({req, " strobe"}, {31'd0, enter}, 32'd1);
    chk({req, " vector"}, vector, vec);
    chk({req, " status"}, st_new, want_status(status, m, f));
    chk({req, " saved"}, st_saved, status);
    chk({req, " link"}, link, pc + 32'(ofs));
  endtask

  task automatic quiet();
    fiq_n = 1'b1; irq_n = 1'b1; dabt = 1'b0; pabt = 1'b0;
    und = 1'b0; swi = 1'b0; insn_end = 1'b0;
    tick(); tick();
  endtask

  task automatic t_block_reset();
    fiq_n = 1'b0; insn_end = 1'b1;
    tick(); tick();
    chk("R11 strobe in reset", {31'd0, enter}, 32'd0);
    chk("R11 vector cleared", vector, 32'd0);
    chk("R11 link cleared", link, 32'd0);
    chk("R11 status cleared", st_new, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R11 sync preset high", {31'd0, enter}, 32'd0);
    tick();
    expect_entry("R7 fiq after sync", 32'h1C, 5'b10001, 1'b1, 4);
    quiet();
  endtask

  task automatic t_each_kind();
    pc = 32'h0000_2000; status = 32'hA000_0010;
    dabt = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R2 R3 R6 data abort", 32'h10, 5'b10111, 1'b0, 8);
    quiet();
    pabt = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R2 R3 prefetch abort", 32'h0C, 5'b10111, 1'b0, 4);
    quiet();
    und = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R2 R3 undefined", 32'h04, 5'b11011, 1'b0, 4);
    quiet();
    swi = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R2 R3 software int", 32'h08, 5'b10011, 1'b0, 4);
    quiet();
    irq_n = 1'b0; tick(); insn_end = 1'b1; tick();
    expect_entry("R2 R4 normal int", 32'h18, 5'b10010, 1'b0, 4);
    quiet();
  endtask

  task automatic t_collisions();
    pc = 32'h0000_3000; status = 32'h0000_0013;
    fiq_n = 1'b0; tick();
    dabt = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R1 dabt over fiq", 32'h10, 5'b10111, 1'b0, 8);
    dabt = 1'b0; tick();
    expect_entry("R1 fiq next", 32'h1C, 5'b10001, 1'b1, 4);
    quiet();
    irq_n = 1'b0; tick();
    pabt = 1'b1; insn_end = 1'b1; tick();
    expect_entry("R1 irq over pabt", 32'h18, 5'b10010, 1'b0, 4);
    irq_n = 1'b1; tick(); tick();
    expect_entry("R1 pabt next", 32'h0C, 5'b10111, 1'b0, 4);
    quiet();
    pabt = 1'b1; und = 1'b1; insn_end = 1'b1; tick();
    chk("R1 pabt over und", vector, 32'h0C);
    pabt = 1'b0; tick();
    chk("R1 und next", vector, 32'h04);
    quiet();
  endtask

  task automatic t_masks_and_sync();
    pc = 32'h0000_4000;
    status = 32'h0000_0090;  // I masked
    irq_n = 1'b0; tick(); insn_end = 1'b1; tick();
    chk("R7 irq masked by bit7", {31'd0, enter}, 32'd0);
    status = 32'h0000_0050;  // F masked, I clear
    fiq_n = 1'b0; tick(); tick();
    expect_entry("R7 fiq masked irq taken", 32'h18, 5'b10010, 1'b0, 4);
    quiet();
    status = 32'h0000_0010;
    irq_n = 1'b0; insn_end = 1'b1; tick();
    chk("R7 one-clock sync delay", {31'd0, enter}, 32'd0);
    tick();
    chk("R7 taken after delay", {31'd0, enter}, 32'd1);
    quiet();
  endtask

  task automatic t_boundary_idle();
    pc = 32'h0000_5000; status = 32'h0000_001F;
    dabt = 1'b1; insn_end = 1'b0; tick();
    chk("R8 no boundary no entry", {31'd0, enter}, 32'd0);
    insn_end = 1'b1; tick();
    expect_entry("R8 boundary entry", 32'h10, 5'b10111, 1'b0, 8);
    dabt = 1'b0; pc = 32'h0000_5555; status = 32'h1234_5610; tick();
    chk("R10 idle strobe low", {31'd0, enter}, 32'd0);
    chk("R10 vector held", vector, 32'h10);
    chk("R10 link held", link, 32'h0000_5008);
    chk("R10 saved held", st_saved, 32'h0000_001F);
    quiet();
  endtask

  task automatic t_core_reset();
    pc = 32'h0000_6000; status = 32'h0000_0010;
    core_rst = 1'b1; dabt = 1'b1; insn_end = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 no entry while reset", {31'd0, enter}, 32'd0);
    end
    core_rst = 1'b0; insn_end = 1'b0; tick();
    chk("R9 release strobe", {31'd0, enter}, 32'd1);
    chk("R9 release vector", vector, 32'h00);
    chk("R9 release mode", {27'd0, st_new[4:0]}, 32'h13);
    chk("R9 release masks", {30'd0, st_new[7:6]}, 32'd3);
    insn_end = 1'b1; tick();
    expect_entry("R1 dabt after reset", 32'h10, 5'b10111, 1'b0, 8);
    quiet();
  endtask

  initial begin
    @(negedge clk);
    t_block_reset();
    t_each_kind();
    t_collisions();
    t_masks_and_sync();
    t_boundary_idle();
    t_core_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule